// File: doc/BRIEF.md
# Group Address Hash Filter

This block decides whether an incoming frame addressed to a group (multicast) destination should be kept. The 48-bit destination address is delivered one byte per accepted beat. While the bytes arrive, a 32-bit cyclic redundancy check is accumulated over them. When the last byte has been taken, the top six bits of the remainder pick one bit of a 64-entry hash table, and that bit decides acceptance.

The table is supplied by the host as two 32-bit words. A second host control forces acceptance of every group address regardless of the table. A master group-enable control must also be set for anything to be accepted. The computed hash index is always presented, so a host can learn which table bit a given group address maps to. Frames whose destination is an individual address are never accepted by this unit.

Top module: `grp_hash_filter`

## Requirements
- R1: After reset, `res_valid` and `res_accept` are 0.
- R2: The remainder starts at all ones when a byte arrives with `addr_start`=1. Each byte is consumed least-significant bit first. Per bit, the feedback is remainder bit 31 XOR the input bit; the remainder shifts left by one, and when the feedback is 1 it is XORed with 0x04C11DB7. No final inversion is applied, and `res_index` equals remainder bits 31 to 26 after the sixth byte.
- R3: `res_valid` is a one-cycle pulse in the cycle after the sixth byte is taken, and `res_accept` is 0 whenever `res_valid` is 0.
- R4: With enable set and the override clear, index values 0 to 31 accept when bit `index` of `tbl_lo` is 1, and index values 32 to 63 accept when bit `index-32` of `tbl_hi` is 1.
- R5: A destination is a group address when bit 0 of its first byte is 1. `res_group` reports this, and a non-group destination always gives `res_accept`=0.
- R6: With `grp_enable`=0 during the sixth byte, `res_accept` is 0.
- R7: With `grp_enable`=1 and `accept_all`=1 during the sixth byte, every group destination is accepted whatever the table holds.
- R8: A byte with `addr_start`=1 restarts the address even mid-sequence. Bytes with `addr_start`=0 while no address is in progress are ignored and produce no `res_valid`.
- R9: Cycles with `addr_valid`=0 between bytes pause the sequence without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | `addr_byte` carries an address byte this cycle |
| addr_start | input | 1 | This byte is the first of a destination address |
| addr_byte | input | 8 | Address byte, first byte first |
| tbl_lo | input | 32 | Hash table bits for index 0 to 31 |
| tbl_hi | input | 32 | Hash table bits for index 32 to 63 |
| grp_enable | input | 1 | Master enable for group acceptance |
| accept_all | input | 1 | Accept every group destination |
| res_valid | output | 1 | Result pulse |
| res_index | output | 6 | Hash index of the last address |
| res_group | output | 1 | Last address was a group address |
| res_accept | output | 1 | Frame accepted (valid with `res_valid`) |

## Verification
A wrong remainder bit or wrong bit order shows up as a `res_index` mismatch in the result pulse that closes the very address it occurred in, and random addresses reach every index bit within a few dozen frames. A byte counter that drifts shows as a missing, early or doubled `res_valid` pulse, visible at the first address after the fault, including addresses broken by idle cycles or restarted. A wrong table split or gating shows as a `res_accept` mismatch against the table bit chosen by the model's index, in the same cycle.

// File: rtl/ghf_pkg.sv
package ghf_pkg;
   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_COLLECT = 1'b1} seq_state_t;

   localparam int unsigned DEF_ADDR_BYTES = 6;
   localparam int unsigned DEF_HASH_W     = 6;
   localparam int unsigned DEF_WORD_W     = 32;
   localparam int unsigned DEF_CRC_W      = 32;
endpackage

// File: rtl/ghf_byte_seq.sv
module ghf_byte_seq
   import ghf_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES,
   parameter int unsigned BYTE_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_valid,
   input  logic              addr_start,
   input  logic [BYTE_W-1:0] addr_byte,
   output logic              take,
   output logic              seed,
   output logic              last,
   output logic              group_now
);
   localparam int unsigned CNT_W = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

   seq_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             group_q;

   initial assert (ADDR_BYTES >= 2) else $error("ADDR_BYTES must be at least 2");

   assign seed      = addr_valid && addr_start;
   assign take      = addr_valid && (addr_start || state_q == SEQ_COLLECT);
   assign last      = take && !seed && (cnt_q == LAST_CNT);
   assign group_now = seed ? addr_byte[0] : group_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
         group_q <= 1'b0;
      end else if (take) begin
         if (seed) begin
            group_q <= addr_byte[0];
            state_q <= SEQ_COLLECT;
            cnt_q   <= CNT_W'(1);
         end else if (last) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
         end
      end
   end

   AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_IDLE) |-> (cnt_q == '0)); // R8
   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_CNT); // R3
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (state_q == SEQ_IDLE)); // R3
endmodule

// File: rtl/ghf_crc_acc.sv
module ghf_crc_acc #(
   parameter int unsigned   CRC_W    = 32,
   parameter int unsigned   BYTE_W   = 8,
   parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] CRC_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              seed,
   input  logic [BYTE_W-1:0] data,
   output logic [CRC_W-1:0]  crc_next
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stage [BYTE_W+1];

   assign stage[0] = seed ? CRC_INIT : crc_q;

   for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      logic fb;
      assign fb = stage[b][CRC_W-1] ^ data[b];
      assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
   end

   assign crc_next = stage[BYTE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) crc_q <= CRC_INIT;
      else if (take) crc_q <= crc_next;
   end

   AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(crc_q)); // R9
endmodule

// File: rtl/ghf_tbl_pick.sv
module ghf_tbl_pick #(
   parameter int unsigned HASH_W = 6,
   parameter int unsigned WORD_W = 32
) (
   input  logic [HASH_W-1:0] idx,
   input  logic [WORD_W-1:0] tbl_lo,
   input  logic [WORD_W-1:0] tbl_hi,
   output logic              hit
);
   localparam int unsigned BIT_W   = $clog2(WORD_W);
   localparam int unsigned ENTRIES = 1 << HASH_W;

   initial assert (ENTRIES == 2 * WORD_W) else $error("table must be two words");

   logic [BIT_W-1:0]  bit_sel;
   logic [WORD_W-1:0] word;

   assign bit_sel = idx[BIT_W-1:0];

   if (HASH_W == BIT_W + 1) begin : g_two_words
      assign word = idx[HASH_W-1] ? tbl_hi : tbl_lo;
   end else begin : g_flat
      logic [2*WORD_W-1:0] flat;
      assign flat = {tbl_hi, tbl_lo};
      assign word = flat[WORD_W-1:0];
   end

   assign hit = word[bit_sel];
endmodule

// File: rtl/grp_hash_filter.sv
module grp_hash_filter
   import ghf_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES,
   parameter int unsigned HASH_W     = DEF_HASH_W,
   parameter int unsigned WORD_W     = DEF_WORD_W,
   parameter int unsigned CRC_W      = DEF_CRC_W,
   parameter logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] CRC_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_valid,
   input  logic              addr_start,
   input  logic [7:0]        addr_byte,
   input  logic [WORD_W-1:0] tbl_lo,
   input  logic [WORD_W-1:0] tbl_hi,
   input  logic              grp_enable,
   input  logic              accept_all,
   output logic              res_valid,
   output logic [HASH_W-1:0] res_index,
   output logic              res_group,
   output logic              res_accept
);
   localparam int unsigned BYTE_W = 8;

   initial assert (HASH_W <= CRC_W) else $error("HASH_W wider than CRC");

   logic              take, seed, last, group_now, hit;
   logic [CRC_W-1:0]  crc_next;
   logic [HASH_W-1:0] idx_now;

   ghf_byte_seq #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_start(addr_start),
      .addr_byte(addr_byte), .take(take), .seed(seed), .last(last),
      .group_now(group_now));

   ghf_crc_acc #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .CRC_POLY(CRC_POLY),
                 .CRC_INIT(CRC_INIT)) i_crc (
      .clk(clk), .rst_n(rst_n), .take(take), .seed(seed), .data(addr_byte),
      .crc_next(crc_next));

   assign idx_now = crc_next[CRC_W-1 -: HASH_W];

   ghf_tbl_pick #(.HASH_W(HASH_W), .WORD_W(WORD_W)) i_pick (
      .idx(idx_now), .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .hit(hit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_index  <= '0;
         res_group  <= 1'b0;
      end else begin
         res_valid  <= last;
         res_accept <= last && group_now && grp_enable && (accept_all || hit);
         if (last) begin
            res_index <= idx_now;
            res_group <= group_now;
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R3
   AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      res_accept |-> res_valid); // R3
   AST_GROUP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      res_accept |-> res_group); // R5
   AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      res_accept |-> $past(grp_enable)); // R6
   AST_ALL_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_group && $past(grp_enable) && $past(accept_all)) |-> res_accept); // R7
endmodule

// File: tb/test_grp_hash_filter.sv
module test_grp_hash_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_valid = 1'b0, addr_start = 1'b0;
   logic [7:0]  addr_byte = '0;
   logic [31:0] tbl_lo = '0, tbl_hi = '0;
   logic        grp_enable = 1'b0, accept_all = 1'b0;
   logic        res_valid, res_group, res_accept;
   logic [5:0]  res_index;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   grp_hash_filter i_grp_hash_filter (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_start(addr_start),
      .addr_byte(addr_byte), .tbl_lo(tbl_lo), .tbl_hi(tbl_hi),
      .grp_enable(grp_enable), .accept_all(accept_all), .res_valid(res_valid),
      .res_index(res_index), .res_group(res_group), .res_accept(res_accept));

   function automatic logic [31:0] ref_crc(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] d = a[8*i +: 8];
         for (int j = 0; j < 8; j++) begin
            logic fb = c[31] ^ d[j];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return c;
   endfunction

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c = ref_crc(a);
      return c[31:26];
   endfunction

   function automatic logic ref_acc(input logic [47:0] a);
      logic [5:0] ix = ref_idx(a);
      logic tb = ix[5] ? tbl_hi[ix[4:0]] : tbl_lo[ix[4:0]];
      return a[0] && grp_enable && (accept_all || tb);
   endfunction

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] b, input logic first);
      @(negedge clk);
      addr_valid = 1'b1;
      addr_start = first;
      addr_byte  = b;
   endtask

   task automatic idle_beat();
      @(negedge clk);
      addr_valid = 1'b0;
      addr_start = 1'b0;
   endtask

   task automatic send_addr(input logic [47:0] a, input int gap_pct);
      for (int i = 0; i < 6; i++) begin
         if (i > 0 && ($urandom % 100) < gap_pct) idle_beat();
         put_byte(a[8*i +: 8], i == 0);
      end
      idle_beat();
   endtask

   task automatic check_res(input string req, input logic [47:0] a);
      chk(req, "res_valid", res_valid, 1);
      chk("R2", "res_index", res_index, ref_idx(a));
      chk("R5", "res_group", res_group, a[0]);
      chk(req, "res_accept", res_accept, ref_acc(a));
      @(negedge clk);
      chk("R3", "res_valid pulse end", res_valid, 0);
      chk("R3", "res_accept without valid", res_accept, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [47:0] a, b;
      logic [5:0]  ix;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", "res_valid after reset", res_valid, 0);
      chk("R1", "res_accept after reset", res_accept, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "res_valid idle", res_valid, 0);

      // R2: a fixed group address, all-ones table
      grp_enable = 1; tbl_lo = '1; tbl_hi = '1;
      a = 48'h0000_5E00_0001 | 48'h1;
      send_addr(a, 0); check_res("R2", a);

      // R4: one-hot table at the model index accepts, inverse rejects
      for (int k = 0; k < 8; k++) begin
         a = {$urandom, $urandom} | 48'h1;
         ix = ref_idx(a);
         tbl_lo = '0; tbl_hi = '0;
         if (ix[5]) tbl_hi[ix[4:0]] = 1'b1; else tbl_lo[ix[4:0]] = 1'b1;
         accept_all = 0; grp_enable = 1;
         send_addr(a, 0); check_res("R4", a);
         chk("R4", "one-hot accept", ref_acc(a), 1);
         tbl_lo = ~tbl_lo; tbl_hi = ~tbl_hi;
         send_addr(a, 0); check_res("R4", a);
      end

      // R5: individual address never accepted
      tbl_lo = '1; tbl_hi = '1; accept_all = 1;
      a = 48'hA1B2_C3D4_E5F6 & ~48'h1;
      send_addr(a, 0); check_res("R5", a);

      // R6: enable low blocks acceptance
      grp_enable = 0;
      a = 48'h0100_0000_0001;
      send_addr(a, 0); check_res("R6", a);

      // R7: override with empty table
      grp_enable = 1; accept_all = 1; tbl_lo = '0; tbl_hi = '0;
      a = 48'h3300_0000_0033 | 48'h1;
      send_addr(a, 0); check_res("R7", a);
      accept_all = 0;
      send_addr(a, 0); check_res("R7", a);

      // R8: orphan bytes ignored
      for (int i = 0; i < 8; i++) begin
         put_byte(8'(i * 37 + 1), 1'b0);
      end
      idle_beat();
      for (int i = 0; i < 3; i++) begin
         chk("R8", "orphan bytes give no result", res_valid, 0);
         @(negedge clk);
      end

      // R8: restart mid-sequence
      tbl_lo = 32'h5A5A_1234; tbl_hi = 32'hC3C3_8765;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom} | 48'h1;
      for (int i = 0; i < 4; i++) put_byte(a[8*i +: 8], i == 0);
      send_addr(b, 0);
      check_res("R8", b);

      // R9 and random mix
      for (int n = 0; n < 300; n++) begin
         a = {$urandom, $urandom};
         tbl_lo = $urandom; tbl_hi = $urandom;
         grp_enable = ($urandom % 8) != 0;
         accept_all = ($urandom % 6) == 0;
         send_addr(a, (n % 2) ? 40 : 0);
         check_res((n % 2) ? "R9" : "R4", a);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule